// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Coherent Snapshot

This block is a free-running real-time clock for the always-on domain of a chip. It runs directly from a 32.768 kHz clock that stays on while the rest of the chip sleeps. Each rising edge of `clk` is one tick of that source. The block keeps a seconds count and a milliseconds count within the current second. Both counts are visible through a small synchronous 32-bit register port.

The 32.768 kHz rate is not a whole multiple of 1 kHz. A fractional accumulator therefore adds a step of 1000 on every tick. It emits a millisecond pulse, and keeps the remainder, each time the running sum reaches 32768. This gives exactly 1000 milliseconds per 32768 ticks, with no drift.

Software cannot read seconds and milliseconds in one access. So a read of the milliseconds register also copies the live seconds value into a snapshot register, on the same clock edge. Software reads milliseconds first and then the snapshot. The two values form one consistent pair, even when a seconds carry falls between the two reads. The snapshot register is shared. If two agents interleave their read pairs, each overwrites the other's snapshot, so only one reader may use the pair sequence at a time. Software can also write the seconds register directly, which restarts the sub-second state.

Top module: `msrtc_top`

## Requirements
- R1: After a synchronous active-low reset, the live seconds, the milliseconds and the snapshot registers all read as 0.
- R2: After N clock edges counted from reset release or from a seconds write, the total elapsed milliseconds equal floor(N*1000/32768). Millisecond pulses are therefore 32 or 33 edges apart, and never on two consecutive edges.
- R3: The milliseconds value stays in 0..999. When it would pass 999, it returns to 0 and the seconds count rises by 1 on the same edge.
- R4: A read at offset 0x10 returns the milliseconds value. On the same edge, it copies the live seconds value into the snapshot register, which is readable at offset 0x0C.
- R5: The snapshot register changes only on a read at offset 0x10. Time advancing and reads of other offsets leave it unchanged.
- R6: A write at offset 0x08 loads the seconds count with the written data and clears the milliseconds and the fractional accumulator. The load takes priority over a carry on the same edge.
- R7: Writes at 0x0C, 0x10 or any other offset than 0x08 have no effect on any register.
- R8: Read data is registered. It is updated on the edge that performs a read and holds its value until the next read. A read of an unmapped offset returns 0.
- R9: The seconds count wraps from 0xFFFFFFFF to 0 on a carry.
- R10: A read at offset 0x08 returns the live seconds count as it stands before the access edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz always-on clock; one tick per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Every access takes effect on the rising edge at which `bus_sel` is sampled high. The read data, the snapshot and any seconds load are visible right after that edge, and reflect the counter state from before that edge. The bench drives each access on a falling edge and samples `bus_rdata` on the next falling edge. It keeps its own count of edges since reset or since the last seconds write, and reads that count at the moment it drives the access. From that count it predicts the milliseconds and seconds with the floor formula. It aims its reads at chosen counts such as 32, 33, 32767 and 32768, so the first pulse, the 32/33 spacing, the carry and the wrap each land on a known edge.

// File: rtl/msrtc_pkg.sv
// Package msrtc_pkg
// Shared register offsets and the decoded-register type for the
// millisecond real-time clock. Offsets are byte addresses on an 8-bit
// register port; the top module widens them to its own address width.
package msrtc_pkg;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFF_SEC_LIVE = 8'h08;
    localparam logic [7:0] OFF_SEC_SNAP = 8'h0C;
    localparam logic [7:0] OFF_MSEC     = 8'h10;

    // Result of decoding one bus address
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_SEC  = 2'd1,
        RSEL_SNAP = 2'd2,
        RSEL_MSEC = 2'd3
    } rsel_e;

endpackage

// File: rtl/msrtc_frac_tick.sv
// Module msrtc_frac_tick
// Fractional divider: adds STEP every clock edge and emits a one-cycle
// tick whenever the running sum reaches MODULUS, keeping the remainder.
// Assumes 0 < STEP < MODULUS. 'clear' restarts the accumulator at zero.
module msrtc_frac_tick #(
    parameter int unsigned STEP    = 1000,
    parameter int unsigned MODULUS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int unsigned ACC_W = $clog2(MODULUS + STEP) + 1;
    localparam int unsigned QUOT  = MODULUS / STEP;
    localparam int unsigned GAP_W = $clog2(QUOT + 2) + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic [GAP_W-1:0] gap_q;

    // Next accumulator value and the threshold compare
    always_comb begin
        acc_sum = acc_q + ACC_W'(STEP);
        tick    = (acc_sum >= ACC_W'(MODULUS));
    end

    // Accumulator register: restart, wrap with remainder, or add
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            acc_q <= '0;
        else if (tick)
            acc_q <= acc_sum - ACC_W'(MODULUS);
        else
            acc_q <= acc_sum;
    end

    // Cycles since the last tick, kept for the spacing check
    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick)
            gap_q <= '0;
        else
            gap_q <= gap_q + 1'b1;
    end

    // R2: the remainder always stays below the modulus
    a_r2_acc_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < ACC_W'(MODULUS));

    // R2: ticks are spaced by floor or ceil of MODULUS/STEP edges
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q >= GAP_W'(QUOT - 1) && gap_q <= GAP_W'(QUOT)));

    // R2: no two ticks on consecutive edges
    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> !tick);

endmodule

// File: rtl/msrtc_time_cnt.sv
// Module msrtc_time_cnt
// Milliseconds-within-second counter and seconds counter. A tick advances
// the milliseconds; passing MS_MAX-1 returns them to zero and carries into
// seconds, which wrap at 2**SEC_W. A load writes seconds and clears the
// milliseconds, and wins over a tick on the same edge.
module msrtc_time_cnt #(
    parameter int unsigned MS_MAX = 1000,
    parameter int unsigned SEC_W  = 32,
    localparam int unsigned MS_W  = $clog2(MS_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    output logic [SEC_W-1:0] sec,
    output logic [MS_W-1:0]  msec
);
    logic ms_last;

    // Marks the last millisecond of a second
    always_comb ms_last = (msec == MS_W'(MS_MAX - 1));

    // Milliseconds register: clear, load, wrap or step
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            msec <= '0;
        else if (tick)
            msec <= ms_last ? '0 : msec + 1'b1;
    end

    // Seconds register: clear, direct load, or carry from milliseconds
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec <= '0;
        else if (load)
            sec <= load_val;
        else if (tick && ms_last)
            sec <= sec + SEC_W'(1);
    end

    // R3: the milliseconds value never leaves its range
    a_r3_ms_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        msec <= MS_W'(MS_MAX - 1));

    // R3: the carry clears the milliseconds and steps seconds together (R9 wrap included)
    a_r3_carry_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && ms_last) |=> (msec == '0 && sec == $past(sec) + SEC_W'(1)));

    // R6: a load sets seconds and clears milliseconds on the next edge
    a_r6_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sec == $past(load_val) && msec == '0));

    // R3: seconds move only by a carry or a load
    a_r3_sec_only_on_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(tick && ms_last)) |=> $stable(sec));

endmodule

// File: rtl/msrtc_bus_regs.sv
// Module msrtc_bus_regs
// Register port: decodes one access per cycle, issues the seconds load,
// holds the seconds snapshot taken by a milliseconds read, and registers
// the read data. Assumes accesses are synchronous to clk and that at most
// one reader uses the milliseconds/snapshot pair sequence at a time.
module msrtc_bus_regs
    import msrtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned MS_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [MS_W-1:0]   msec_i,
    output logic              load,
    output logic [SEC_W-1:0]  load_val,
    output logic [DATA_W-1:0] rdata
);
    rsel_e             rsel;
    logic              rd_en;
    logic              rd_ms;
    logic [SEC_W-1:0]  snap_q;
    logic [DATA_W-1:0] rd_next;

    // Address decode for the three mapped offsets
    always_comb begin
        if (addr == ADDR_W'(OFF_SEC_LIVE))
            rsel = RSEL_SEC;
        else if (addr == ADDR_W'(OFF_SEC_SNAP))
            rsel = RSEL_SNAP;
        else if (addr == ADDR_W'(OFF_MSEC))
            rsel = RSEL_MSEC;
        else
            rsel = RSEL_NONE;
    end

    // Access qualifiers and the seconds load request
    always_comb begin
        rd_en    = sel && !wr;
        rd_ms    = rd_en && (rsel == RSEL_MSEC);
        load     = sel && wr && (rsel == RSEL_SEC);
        load_val = SEC_W'(wdata);
    end

    // Read multiplexer, zero for unmapped offsets
    always_comb begin
        unique case (rsel)
            RSEL_SEC:  rd_next = DATA_W'(sec_i);
            RSEL_SNAP: rd_next = DATA_W'(snap_q);
            RSEL_MSEC: rd_next = DATA_W'(msec_i);
            default:   rd_next = '0;
        endcase
    end

    // Snapshot register: copies seconds on a milliseconds read
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (rd_ms)
            snap_q <= sec_i;
    end

    // Read data register: updated only by reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end

    // R4: milliseconds and snapshot come from the same pre-edge state
    a_r4_pair_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ms |=> (snap_q == $past(sec_i) && rdata == DATA_W'($past(msec_i))));

    // R5: the snapshot is untouched without a milliseconds read
    a_r5_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ms |=> $stable(snap_q));

    // R8: read data holds between reads
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R8: an unmapped read returns zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rsel == RSEL_NONE) |=> rdata == '0);

endmodule

// File: rtl/msrtc_top.sv
// Module msrtc_top
// Millisecond real-time clock for the always-on domain. Each clk edge is
// one tick of a 32.768 kHz source; a fractional divider turns the ticks
// into exact millisecond pulses that drive the seconds/milliseconds
// counters. A register port gives live seconds, milliseconds and a seconds
// snapshot taken by the milliseconds read.
module msrtc_top #(
    parameter int unsigned SRC_HZ = 32768,
    parameter int unsigned MS_HZ  = 1000,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned MS_W = $clog2(MS_HZ);

    logic             ms_tick;
    logic             sec_load;
    logic [SEC_W-1:0] sec_load_val;
    logic [SEC_W-1:0] sec_cnt;
    logic [MS_W-1:0]  ms_cnt;

    msrtc_frac_tick #(
        .STEP    (MS_HZ),
        .MODULUS (SRC_HZ)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sec_load),
        .tick  (ms_tick)
    );

    msrtc_time_cnt #(
        .MS_MAX (MS_HZ),
        .SEC_W  (SEC_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (ms_tick),
        .load     (sec_load),
        .load_val (sec_load_val),
        .sec      (sec_cnt),
        .msec     (ms_cnt)
    );

    msrtc_bus_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEC_W  (SEC_W),
        .MS_W   (MS_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .sec_i    (sec_cnt),
        .msec_i   (ms_cnt),
        .load     (sec_load),
        .load_val (sec_load_val),
        .rdata    (bus_rdata)
    );

endmodule

// File: tb/msrtc_top_bench.sv
// Directed bench for msrtc_top. Inputs change on falling edges; each
// access is sampled on the following falling edge. A bench-side edge
// count since reset or the last seconds write predicts the time.
module msrtc_top_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    int unsigned edges  = 0;
    logic [31:0] base_sec = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    msrtc_top u_msrtc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Edge count since reset or since the last seconds write
    always @(posedge clk) begin
        if (!rst_n || (bus_sel && bus_wr && bus_addr == 8'h08))
            edges <= 0;
        else
            edges <= edges + 1;
    end

    function automatic longint unsigned tot_ms(input int unsigned c);
        return (longint'(c) * 1000) / 32768;
    endfunction

    function automatic logic [31:0] exp_ms(input int unsigned c);
        return 32'(tot_ms(c) % 1000);
    endfunction

    function automatic logic [31:0] exp_sec(input int unsigned c);
        return base_sec + 32'(tot_ms(c) / 1000);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output int unsigned c);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        c = edges;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        if (a == 8'h08) base_sec = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wait_edges(input int unsigned t);
        while (edges < t) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d; int unsigned c;
        bus_read(8'h0C, d, c); check("R1 snapshot after reset", d, 32'd0);
        bus_read(8'h08, d, c); check("R1 seconds after reset", d, 32'd0);
        bus_read(8'h10, d, c); check("R1 msec after reset", d, 32'd0);
    endtask

    task automatic t_frac_and_carry();
        logic [31:0] d; int unsigned c;
        bus_write(8'h08, 32'd5);
        wait_edges(32);    bus_read(8'h10, d, c); check("R2 no pulse before edge 33", d, exp_ms(c));
        wait_edges(33);    bus_read(8'h10, d, c); check("R2 first pulse at edge 33", d, exp_ms(c));
        wait_edges(1000);  bus_read(8'h10, d, c); check("R2 msec at 1000 edges", d, exp_ms(c));
        wait_edges(32767); bus_read(8'h10, d, c); check("R3 last msec of second", d, exp_ms(c));
        bus_read(8'h0C, d, c); check("R4 snapshot before carry", d, 32'd5);
        wait_edges(32768); bus_read(8'h10, d, c); check("R3 msec wraps to 0", d, 32'd0);
        bus_read(8'h0C, d, c); check("R3 seconds carried into snapshot", d, 32'd6);
        bus_read(8'h08, d, c); check("R10 live seconds", d, exp_sec(c));
    endtask

    task automatic t_snapshot_hold();
        logic [31:0] d; int unsigned c;
        wait_edges(65540);
        bus_read(8'h08, d, c); check("R10 live seconds after 2 s", d, 32'd7);
        bus_read(8'h0C, d, c); check("R5 snapshot unchanged by time", d, 32'd6);
    endtask

    task automatic t_ignored_writes();
        logic [31:0] d; int unsigned c;
        bus_write(8'h0C, 32'hDEAD_BEEF);
        bus_write(8'h10, 32'h0000_0123);
        bus_write(8'h3C, 32'hFFFF_FFFF);
        bus_read(8'h0C, d, c); check("R7 snapshot ignores writes", d, 32'd6);
        bus_read(8'h10, d, c); check("R7 msec ignores writes", d, exp_ms(c));
        bus_read(8'h08, d, c); check("R7 seconds ignores writes", d, exp_sec(c));
    endtask

    task automatic t_load();
        logic [31:0] d; int unsigned c;
        bus_write(8'h08, 32'd100);
        bus_read(8'h10, d, c); check("R6 msec cleared by load", d, 32'd0);
        bus_read(8'h0C, d, c); check("R6 loaded seconds captured", d, 32'd100);
        wait_edges(32); bus_read(8'h10, d, c); check("R6 accumulator cleared by load", d, 32'd0);
        wait_edges(33); bus_read(8'h10, d, c); check("R6 first pulse 33 edges after load", d, 32'd1);
    endtask

    task automatic t_read_path();
        logic [31:0] d; int unsigned c;
        bus_read(8'h04, d, c); check("R8 unmapped read is zero", d, 32'd0);
        wait_edges(70); bus_read(8'h10, d, c); check("R8 msec read", d, exp_ms(c));
        repeat (40) @(negedge clk);
        check("R8 read data holds between reads", bus_rdata, 32'd2);
    endtask

    task automatic t_wrap();
        logic [31:0] d; int unsigned c;
        bus_write(8'h08, 32'hFFFF_FFFF);
        wait_edges(32768);
        bus_read(8'h10, d, c); check("R9 msec at wrap", d, 32'd0);
        bus_read(8'h0C, d, c); check("R9 seconds wrap to 0", d, 32'd0);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_frac_and_carry();
        t_snapshot_hold();
        t_ignored_writes();
        t_load();
        t_read_path();
        t_wrap();
        report();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

endmodule